// File: doc/BRIEF.md
# Keyboard Input Port

A small input-device controller that sits on a 16-bit memory-mapped bus. A keyboard front end hands it 8-bit character codes, each marked by a one-cycle strobe. The port keeps a single character. It raises a ready flag when that character is captured, and from then on it refuses new keystrokes until the processor fetches the character from the data register.

Software can poll the status register at 0xFE00 or set its interrupt-enable bit, so that the port raises an interrupt request while a character is waiting. The character itself is read from 0xFE02. Reading it is the only event that clears the ready flag and lets the keyboard deliver again.

Read data is combinational from the port's registers in the cycle of the request. Side effects of a read or write take hold at the next rising clock edge.

Top module: `kbd_in_port`

## Requirements
- R1: After reset the ready flag and the interrupt enable are zero, irq is low, and a status read returns 0x0000.
- R2: A strobe arriving while ready is zero, and not in a data-register read cycle, stores key_code. From the following cycle, status bit 15 reads one.
- R3: A read of 0xFE02 returns the stored code in bits [7:0] and zero in bits [15:8].
- R4: While ready is one, strobes are discarded and the stored code stays unchanged.
- R5: A read of 0xFE02 clears ready from the next cycle on. A later strobe is then captured again.
- R6: A strobe in the same cycle as a read of 0xFE02 is discarded. The read returns the previously stored code.
- R7: A write to 0xFE00 loads bit 14 of the write data into the interrupt enable. Write-data bit 15 does not change ready, and status bits 13:0 always read zero.
- R8: irq is high exactly in the cycles where both ready and the interrupt enable are one, with no added delay by default.
- R9: Status reads leave ready unchanged. Writes to 0xFE02 have no effect. Reads of any other address, and any cycle with no read, return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| key_stb | input | 1 | One-cycle strobe marking a new character |
| key_code | input | 8 | Character code accompanying key_stb |
| irq | output | 1 | Interrupt request |

## Verification
bus_rdata and irq are due in the cycle in which the access or state applies: they are read from registers through logic only. Register changes caused by a strobe, a data read or a status write become visible one cycle after the edge that samples them. The bench drives each cycle's inputs just after a falling edge. It compares bus_rdata and irq against a behavioural model shortly before the next rising edge, and advances the model only at that edge. Every result is therefore checked in exactly the cycle in which it is due.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
   typedef enum logic [1:0] {
      KREG_NONE   = 2'd0,
      KREG_STATUS = 2'd1,
      KREG_DATA   = 2'd2
   } kbd_reg_e;
endpackage

// File: rtl/kbd_decode.sv
module kbd_decode
   import kbd_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE02
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output kbd_reg_e          hit,
   output logic              rd_status,
   output logic              rd_data,
   output logic              wr_status
);
   initial begin
      assert (STATUS_ADDR != DATA_ADDR) else $error("kbd_decode: register addresses collide");
   end

   always_comb begin
      hit = KREG_NONE;
      if (bus_sel) begin
         if (bus_addr == STATUS_ADDR)    hit = KREG_STATUS;
         else if (bus_addr == DATA_ADDR) hit = KREG_DATA;
      end
   end

   assign rd_status = (hit == KREG_STATUS) && !bus_we;
   assign rd_data   = (hit == KREG_DATA)   && !bus_we;
   assign wr_status = (hit == KREG_STATUS) &&  bus_we;
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_stb,
   input  logic [CODE_W-1:0] key_code,
   input  logic              rd_clr,
   output logic              ready,
   output logic [CODE_W-1:0] code_q
);
   logic take;

   // A data read wins over a coinciding strobe; the strobe is dropped.
   assign take = key_stb && !ready && !rd_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready  <= 1'b0;
         code_q <= '0;
      end else begin
         if (rd_clr)    ready <= 1'b0;
         else if (take) ready <= 1'b1;
         if (take)      code_q <= key_code;
      end
   end

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_stb && !ready && !rd_clr) |=> (ready && code_q == $past(key_code)));
   assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !rd_clr) |=> (ready && $stable(code_q)));
   assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> !ready);
   assert_drop_same_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && key_stb) |=> $stable(code_q));
endmodule

// File: rtl/kbd_ctrl.sv
module kbd_ctrl #(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_status,
   input  logic ie_wdata,
   input  logic ready,
   output logic ie,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ie <= 1'b0;
      else if (wr_status) ie <= ie_wdata;
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ready && ie;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = ready && ie;
      end
   endgenerate

   assert_ie_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_status |=> (ie == $past(ie_wdata)));
   assert_ie_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_status |=> $stable(ie));
endmodule

// File: rtl/kbd_in_port.sv
module kbd_in_port
   import kbd_pkg::*;
#(
   parameter int                ADDR_W         = 16,
   parameter int                DATA_W         = 16,
   parameter int                CODE_W         = 8,
   parameter logic [ADDR_W-1:0] STATUS_ADDR    = 16'hFE00,
   parameter logic [ADDR_W-1:0] DATA_ADDR      = 16'hFE02,
   parameter int                READY_BIT      = 15,
   parameter int                IE_BIT         = 14,
   parameter bit                IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              key_stb,
   input  logic [CODE_W-1:0] key_code,
   output logic              irq
);
   localparam int PAD_W = DATA_W - CODE_W;

   initial begin
      assert (CODE_W < DATA_W) else $error("kbd_in_port: code wider than bus");
      assert (READY_BIT < DATA_W && IE_BIT < DATA_W) else $error("kbd_in_port: flag bit out of range");
      assert (READY_BIT != IE_BIT) else $error("kbd_in_port: flag bits overlap");
   end

   kbd_reg_e          hit;
   logic              rd_status, rd_data, wr_status;
   logic              ready, ie;
   logic [CODE_W-1:0] code_q;
   logic [DATA_W-1:0] status_word, data_word;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   kbd_decode #(
      .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_decode (
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .hit(hit), .rd_status(rd_status), .rd_data(rd_data), .wr_status(wr_status)
   );

   kbd_capture #(.CODE_W(CODE_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .key_stb(key_stb), .key_code(key_code),
      .rd_clr(rd_data), .ready(ready), .code_q(code_q)
   );

   kbd_ctrl #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_status(wr_status),
      .ie_wdata(bus_wdata[IE_BIT]), .ready(ready), .ie(ie), .irq(irq)
   );

   always_comb begin
      status_word            = '0;
      status_word[READY_BIT] = ready;
      status_word[IE_BIT]    = ie;
   end

   assign data_word = {{PAD_W{1'b0}}, code_q};

   always_comb begin
      unique case (1'b1)
         rd_status: bus_rdata = status_word;
         rd_data:   bus_rdata = data_word;
         default:   bus_rdata = '0;
      endcase
   end

   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data |-> (bus_rdata[DATA_W-1:CODE_W] == '0));
   assert_status_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && ready) |=> ready);
   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == KREG_NONE) |-> (bus_rdata == '0));

   generate
      if (IRQ_REGISTERED) begin : g_chk_reg
         assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(ready && ie));
      end else begin : g_chk_comb
         assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (ready && ie));
      end
   endgenerate
endmodule

// File: tb/tb_kbd_in_port.sv
module tb_kbd_in_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0, key_stb = 1'b0;
   logic [15:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0]  key_code = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_cmp = 0, n_bad = 0;
   bit m_ready = 0, m_ie = 0;
   logic [7:0] m_code = '0;
   localparam logic [15:0] A_ST = 16'hFE00, A_DT = 16'hFE02;

   always #2 clk = ~clk;

   kbd_in_port dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .key_stb(key_stb), .key_code(key_code), .irq(irq)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One bus cycle: drive, compare before the rising edge, advance model at it.
   task automatic step(string req, bit sel, bit we, logic [15:0] addr,
                       logic [15:0] wd, bit stb, logic [7:0] code);
      logic [15:0] exp_rd;
      bit rd_dt;
      bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
      key_stb = stb; key_code = code;
      exp_rd = 16'h0000;
      if (sel && !we && addr == A_ST) exp_rd = {m_ready, m_ie, 14'b0};
      if (sel && !we && addr == A_DT) exp_rd = {8'h00, m_code};
      #1;
      check(req, bus_rdata, exp_rd, "rdata");
      check(req, {15'b0, irq}, {15'b0, m_ready & m_ie}, "irq");
      @(posedge clk);
      rd_dt = sel && !we && addr == A_DT;
      if (sel && we && addr == A_ST) m_ie = wd[14];
      if (rd_dt) m_ready = 0;
      else if (stb && !m_ready) begin m_ready = 1; m_code = code; end
      @(negedge clk);
      bus_sel = 0; key_stb = 0;
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      step("R1", 1, 0, A_ST, 0, 0, 0);
      step("R1", 1, 0, A_DT, 0, 0, 0);
      // R2 capture, R3 upper zero, R5 clear
      step("R2", 0, 0, 0, 0, 1, 8'h41);
      step("R2", 1, 0, A_ST, 0, 0, 0);
      step("R3", 1, 0, A_DT, 0, 0, 0);
      step("R5", 1, 0, A_ST, 0, 0, 0);
      // R4 lockout
      step("R4", 0, 0, 0, 0, 1, 8'hC3);
      step("R4", 0, 0, 0, 0, 1, 8'h7E);
      step("R4", 1, 0, A_DT, 0, 0, 0);
      step("R5", 0, 0, 0, 0, 1, 8'h20);
      // R6 strobe coinciding with a data read, ready set and clear
      step("R6", 1, 0, A_DT, 0, 1, 8'h99);
      step("R6", 1, 0, A_ST, 0, 0, 0);
      step("R6", 1, 0, A_DT, 0, 1, 8'h55);
      step("R6", 1, 0, A_DT, 0, 0, 0);
      // R7 enable write, bit 15 ignored; R8 irq
      step("R7", 1, 1, A_ST, 16'hFFFF, 0, 0);
      step("R7", 1, 0, A_ST, 0, 0, 0);
      step("R8", 0, 0, 0, 0, 1, 8'h0D);
      step("R8", 1, 0, A_ST, 0, 0, 0);
      // R9 status read keeps ready, data write ignored, other addresses zero
      step("R9", 1, 1, A_DT, 16'h1234, 0, 0);
      step("R9", 1, 0, 16'hFE04, 0, 0, 0);
      step("R9", 1, 0, A_ST, 0, 0, 0);
      step("R8", 1, 0, A_DT, 0, 0, 0);
      step("R7", 1, 1, A_ST, 16'h8000, 1, 8'h31);
      step("R7", 1, 0, A_ST, 0, 0, 0);
      // Mixed traffic
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] a;
         case ($urandom_range(3))
            0: a = A_ST; 1: a = A_DT; 2: a = 16'hFE04; default: a = 16'hFE01;
         endcase
         step("R2", 1'($urandom_range(1)), 1'($urandom_range(3) == 0), a,
              16'($urandom), 1'($urandom_range(1)), 8'($urandom));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule